// File: doc/BRIEF.md
# Indirect Address Postcrement Generator

This block sits beside the operand fetch path of a small 16-bit processor and produces the byte address for a memory operand. It also produces the value that the pointer register should hold once the access is done. It handles two ways of forming an address.

In indirect mode the operand address is the current contents of a 16-bit pointer register. A 4-bit modifier code can then move that register forward or backward by 1 to 4 bytes. Word accesses use the same byte-sized steps. In direct mode an 8-bit field from the instruction is a word number, and the block turns it into an even 9-bit byte address. In direct mode the pointer is never written.

The block is purely combinational, so every output follows its inputs within the same cycle. Instruction decode must ensure that at most one operand of an instruction uses indirect addressing. The pointer write-enable tells the register file whether to store the new pointer value.

Top module: `postcrement_addr_gen`

## Requirements
- R1: In indirect mode (`directMode`=0), `effAddr` equals `ptrValue` as presented, which is the value before any adjustment.
- R2: In indirect mode, modifier codes 0, 1, 2 and 3 give `ptrNext` = `ptrValue` + 1, + 2, + 3 and + 4 respectively (code n adds n+1).
- R3: In indirect mode, modifier codes 4, 5, 6 and 7 give `ptrNext` = `ptrValue` − 1, − 2, − 3 and − 4 respectively (code n subtracts n−3).
- R4: In indirect mode, modifier codes 8 to 15 leave `ptrNext` equal to `ptrValue`, with `ptrWe` low.
- R5: Pointer arithmetic wraps modulo 2^16. For example, 0xFFFE with code 3 gives 0x0002, and 0x0001 with code 7 gives 0xFFFD.
- R6: In direct mode (`directMode`=1), `effAddr` equals twice `directField`. Bit 0 is 0, bits 9 to 15 are 0, and the field appears in bits 8 to 1 (field 0x50 gives 0x00A0).
- R7: In direct mode, `ptrWe` is low and `ptrNext` equals `ptrValue`, whatever the modifier code.
- R8: `ptrWe` is high exactly when `directMode` is 0 and the modifier code is in the range 0 to 7.
- R9: All outputs are combinational functions of the present inputs. They are valid in the same cycle, with no state carried between cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ptrValue | input | 16 | Current value of the pointer register |
| modCode | input | 4 | Postcrement modifier code |
| directField | input | 8 | Word address field used in direct mode |
| directMode | input | 1 | 1 selects direct mode, 0 selects indirect through the pointer |
| effAddr | output | 16 | Effective byte address of the access |
| ptrNext | output | 16 | Pointer value to write back |
| ptrWe | output | 1 | Write-enable for the pointer register |

## Verification
The checker's immediate assertions assume that all four inputs hold known values whenever the outputs are evaluated. They also assume that the upper seven bits of a direct byte address are zero only because the default widths are used. The bench sets every input to a defined zero at declaration and only ever drives complete values. It sweeps all sixteen modifier codes against pointers chosen near zero, near the midpoint and near the top of the 16-bit range, and sweeps all 256 direct fields. This keeps every case inside those assumptions while still reaching the wrap boundaries.

// File: rtl/pag_pkg.sv
package pag_pkg;
  localparam int MOD_W   = 4;
  localparam int MAX_STEP = 4;
  localparam int STEP_W  = $clog2(MAX_STEP + 1);

  typedef struct packed {
    logic              useDirect;
    logic              ptrWrite;
    logic              stepDown;
    logic [STEP_W-1:0] stepBytes;
  } stepCtrl_t;
endpackage

// File: rtl/pag_ctrl.sv
module pag_ctrl
  import pag_pkg::*;
(
  input  logic [MOD_W-1:0] modCode,
  input  logic             directMode,
  output stepCtrl_t        ctrl
);
  logic modActive;

  // Codes with the top bit set carry no adjustment.
  assign modActive = ~modCode[MOD_W-1];

  always_comb begin
    ctrl           = '0;
    ctrl.useDirect = directMode;
    ctrl.ptrWrite  = modActive & ~directMode;
    ctrl.stepDown  = modCode[MOD_W-2];
    ctrl.stepBytes = {1'b0, modCode[1:0]} + STEP_W'(1);
  end
endmodule

// File: rtl/pag_datapath.sv
module pag_datapath
  import pag_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int DIR_W = 8
) (
  input  logic [PTR_W-1:0] ptrValue,
  input  logic [DIR_W-1:0] directField,
  input  stepCtrl_t        ctrl,
  output logic [PTR_W-1:0] effAddr,
  output logic [PTR_W-1:0] ptrNext
);
  localparam int PAD_W = PTR_W - DIR_W - 1;

  logic [PTR_W-1:0] directAddr;
  logic [PTR_W-1:0] stepExt;
  logic [PTR_W-1:0] ptrMoved;

  generate
    if (PAD_W > 0) begin : g_pad
      assign directAddr = {{PAD_W{1'b0}}, directField, 1'b0};
    end else begin : g_nopad
      assign directAddr = {directField[PTR_W-2:0], 1'b0};
    end
  endgenerate

  assign stepExt  = PTR_W'(ctrl.stepBytes);
  assign ptrMoved = ctrl.stepDown ? (ptrValue - stepExt) : (ptrValue + stepExt);

  assign effAddr = ctrl.useDirect ? directAddr : ptrValue;
  assign ptrNext = ctrl.ptrWrite  ? ptrMoved   : ptrValue;
endmodule

// File: rtl/postcrement_addr_gen.sv
module postcrement_addr_gen
  import pag_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int DIR_W = 8
) (
  input  logic [PTR_W-1:0] ptrValue,
  input  logic [MOD_W-1:0] modCode,
  input  logic [DIR_W-1:0] directField,
  input  logic             directMode,
  output logic [PTR_W-1:0] effAddr,
  output logic [PTR_W-1:0] ptrNext,
  output logic             ptrWe
);
  stepCtrl_t stepCtrl;

  pag_ctrl u_ctrl (
    .modCode    (modCode),
    .directMode (directMode),
    .ctrl       (stepCtrl)
  );

  pag_datapath #(.PTR_W(PTR_W), .DIR_W(DIR_W)) u_dp (
    .ptrValue    (ptrValue),
    .directField (directField),
    .ctrl        (stepCtrl),
    .effAddr     (effAddr),
    .ptrNext     (ptrNext)
  );

  assign ptrWe = stepCtrl.ptrWrite;
endmodule

// File: rtl/pag_checker.sv
module pag_checker
  import pag_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int DIR_W = 8
) (
  input logic [PTR_W-1:0] ptrValue,
  input logic [MOD_W-1:0] modCode,
  input logic [DIR_W-1:0] directField,
  input logic             directMode,
  input logic [PTR_W-1:0] effAddr,
  input logic [PTR_W-1:0] ptrNext,
  input logic             ptrWe
);
  logic [PTR_W-1:0] fwdDelta;
  logic [PTR_W-1:0] bwdDelta;

  assign fwdDelta = ptrNext - ptrValue;
  assign bwdDelta = ptrValue - ptrNext;

  always_comb begin
    p_indirect_addr_r1: assert (directMode || effAddr == ptrValue)
      else $error("indirect address differs from pointer");
    p_fwd_range_r2: assert (!(ptrWe && !modCode[MOD_W-2]) ||
                            (fwdDelta >= PTR_W'(1) && fwdDelta <= PTR_W'(MAX_STEP)))
      else $error("forward step out of range");
    p_bwd_range_r3: assert (!(ptrWe && modCode[MOD_W-2]) ||
                            (bwdDelta >= PTR_W'(1) && bwdDelta <= PTR_W'(MAX_STEP)))
      else $error("backward step out of range");
    p_hold_r4: assert (ptrWe || ptrNext == ptrValue)
      else $error("pointer changed without write-enable");
    p_direct_even_r6: assert (!directMode || (effAddr[0] == 1'b0 &&
                              effAddr[DIR_W:1] == directField))
      else $error("direct address malformed");
    p_direct_nowrite_r7: assert (!(directMode && ptrWe))
      else $error("pointer write in direct mode");
    p_we_gate_r8: assert (!ptrWe || !modCode[MOD_W-1])
      else $error("write-enable with inactive modifier");
  end
endmodule

bind postcrement_addr_gen pag_checker #(.PTR_W(PTR_W), .DIR_W(DIR_W)) u_pag_chk (
  .ptrValue    (ptrValue),
  .modCode     (modCode),
  .directField (directField),
  .directMode  (directMode),
  .effAddr     (effAddr),
  .ptrNext     (ptrNext),
  .ptrWe       (ptrWe)
);

// File: tb/tb_postcrement_addr_gen.sv
module tb_postcrement_addr_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [15:0] ptrValue    = '0;
  logic [3:0]  modCode     = '0;
  logic [7:0]  directField = '0;
  logic        directMode  = 1'b0;
  logic [15:0] effAddr;
  logic [15:0] ptrNext;
  logic        ptrWe;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  postcrement_addr_gen dut (
    .ptrValue    (ptrValue),
    .modCode     (modCode),
    .directField (directField),
    .directMode  (directMode),
    .effAddr     (effAddr),
    .ptrNext     (ptrNext),
    .ptrWe       (ptrWe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h (ptr=%h mod=%0d fld=%h dir=%0d)",
               req, act, exp, ptrValue, modCode, directField, directMode);
    end
  endtask

  task automatic apply(input logic [15:0] p, input logic [3:0] m,
                       input logic [7:0] f, input logic d);
    @(posedge clk);
    #1;
    ptrValue = p; modCode = m; directField = f; directMode = d;
    #1;
  endtask

  task automatic checkIndirect(input logic [15:0] p, input logic [3:0] m);
    int delta;
    logic [15:0] expNext;
    string tag;
    apply(p, m, 8'hA5, 1'b0);
    if (m < 4)       begin delta = int'(m) + 1; tag = "R2"; end
    else if (m < 8)  begin delta = -(int'(m) - 3); tag = "R3"; end
    else             begin delta = 0; tag = "R4"; end
    expNext = 16'((int'(p) + delta + 65536) % 65536);
    chk("R1 effAddr", effAddr, p);
    chk({tag, " ptrNext"}, ptrNext, expNext);
    chk("R8 ptrWe", {15'd0, ptrWe}, {15'd0, (m < 8)});
  endtask

  logic [15:0] ptrList [12];

  initial begin
    ptrList = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h1234,
                16'h7FFF, 16'h8000, 16'hFFFC, 16'hFFFD, 16'hFFFE, 16'hFFFF};
    // R9: outputs follow inputs during reset, with no state held
    #1;
    chk("R9 reset effAddr", effAddr, 16'h0000);
    chk("R9 reset ptrNext", ptrNext, 16'h0001);
    chk("R9 reset ptrWe", {15'd0, ptrWe}, 16'd1);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    for (int i = 0; i < 12; i++)
      for (int m = 0; m < 16; m++)
        checkIndirect(ptrList[i], 4'(m));

    // R5 wrap corners
    apply(16'hFFFE, 4'd3, 8'h00, 1'b0);
    chk("R5 wrap up", ptrNext, 16'h0002);
    apply(16'h0001, 4'd7, 8'h00, 1'b0);
    chk("R5 wrap down", ptrNext, 16'hFFFD);

    // R6/R7 direct sweep
    for (int f = 0; f < 256; f++)
      for (int m = 0; m < 16; m += 5) begin
        apply(16'h4000 + 16'(f), 4'(m), 8'(f), 1'b1);
        chk("R6 direct effAddr", effAddr, 16'(2 * f));
        chk("R7 direct ptrNext", ptrNext, 16'h4000 + 16'(f));
        chk("R7 direct ptrWe", {15'd0, ptrWe}, 16'd0);
      end
    apply(16'h0000, 4'd0, 8'h50, 1'b1);
    chk("R6 field 50", effAddr, 16'h00A0);

    // R9: switching mode changes outputs in the same cycle
    apply(16'h3000, 4'd1, 8'hFF, 1'b1);
    chk("R9 direct now", effAddr, 16'h01FE);
    apply(16'h3000, 4'd1, 8'hFF, 1'b0);
    chk("R9 indirect now", effAddr, 16'h3000);
    chk("R9 indirect next", ptrNext, 16'h3002);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule